// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a processor interrupt after a programmed number of rendered scanlines. An external one-cycle strobe marks each scanline. An 8-bit down-counter counts these strobes. When the counter is zero, or when the processor has asked for a reload, the next strobe copies a programmed latch value into the counter. Otherwise the strobe decrements the counter. After each strobe, if interrupts are enabled and the counter is zero, a level interrupt request is set. The request stays high until it is acknowledged or interrupts are disabled.

The processor controls the block with writes into the top quarter of its address space. Address bits [15:13] select one of two register pairs, and address bit 0 selects the register within the pair. A dedicated acknowledge input clears the request without changing the enable.

Top module: `scanline_irq_top`

## Requirements
- R1: A write with addr[15:13]=3'b110 and addr[0]=0 stores wr_data as the 8-bit reload latch.
- R2: A write with addr[15:13]=3'b110 and addr[0]=1 forces the counter to 0 and sets a reload-pending flag, so the next tick loads the latch.
- R3: A write with addr[15:13]=3'b111 and addr[0]=0 clears the enable and drops irq_out in the following cycle.
- R4: A write with addr[15:13]=3'b111 and addr[0]=1 sets the enable and leaves a pending request untouched.
- R5: On a tick, the counter loads the latch if reload is pending or the counter is 0, and reload-pending clears. Otherwise the counter decrements by one.
- R6: After a tick, if the enable is set and the counter is 0, irq_out goes high in the next cycle and holds until cleared. With the enable clear, no request is raised.
- R7: With a latch of 0, every tick while enabled raises a request.
- R8: Synchronous reset clears the latch, counter, reload-pending, enable and request.
- R9: irq_ack clears the request. If a tick raises a request in the same cycle, the request is kept.
- R10: A register write and a tick in the same cycle apply the write first, and the tick uses the updated state.
- R11: A write whose addr[15:13] is not 3'b110 or 3'b111 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| line_tick | input | 1 | One-cycle strobe, one per scanline |
| irq_ack | input | 1 | Clears the pending request |
| irq_out | output | 1 | Level interrupt request |

## Verification
The counter, latch and reload flag cannot be read from outside the block. A fault in any of them shows only as irq_out rising on the wrong scanline. Such an error may stay hidden for up to a full latch period of ticks after the fault. For this reason the vector sequence always runs the counter down to the next request after each disturbance. It covers a reload write, a same-cycle write with a tick, and a write outside the window. A fault in the enable or the request flag shows at irq_out in the cycle right after the write or acknowledge that should have changed it.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    localparam int CNT_W = 8;
    localparam int WIN_W = 3;
    localparam logic [WIN_W-1:0] WIN_COUNT  = 3'b110;
    localparam logic [WIN_W-1:0] WIN_ENABLE = 3'b111;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic set_latch;
        logic req_reload;
        logic irq_off;
        logic irq_on;
        cnt_t data;
    } irq_cmd_t;

    function automatic irq_cmd_t decode_write(
        input logic             en,
        input logic [WIN_W-1:0] window,
        input logic             odd,
        input cnt_t             data
    );
        irq_cmd_t c;
        c = '0;
        c.data = data;
        if (en) begin
            if (window == WIN_COUNT) begin
                c.set_latch  = !odd;
                c.req_reload = odd;
            end else if (window == WIN_ENABLE) begin
                c.irq_off = !odd;
                c.irq_on  = odd;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cnt_t              wr_data,
    output irq_cmd_t          cmd
);
    localparam int WIN_LSB = ADDR_W - WIN_W;

    always_comb begin
        cmd = decode_write(wr_en, wr_addr[ADDR_W-1:WIN_LSB], wr_addr[0], wr_data);
    end

    always_comb begin
        assert (!wr_en || $onehot0({cmd.set_latch, cmd.req_reload, cmd.irq_off, cmd.irq_on}))
            else $error("a_r11_one_cmd: more than one command decoded");
    end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_cmd_t cmd,
    input  logic     line_tick,
    output logic     hit
);
    cnt_t latch_q, cnt_q, latch_n, cnt_w, cnt_n;
    logic reload_q, reload_w, reload_n;

    always_comb begin
        latch_n  = cmd.set_latch ? cmd.data : latch_q;
        cnt_w    = cmd.req_reload ? '0 : cnt_q;
        reload_w = cmd.req_reload | reload_q;
        cnt_n    = cnt_w;
        reload_n = reload_w;
        if (line_tick) begin
            if (reload_w || cnt_w == '0) begin
                cnt_n    = latch_n;
                reload_n = 1'b0;
            end else begin
                cnt_n = cnt_w - 1'b1;
            end
        end
        hit = line_tick && (cnt_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else begin
            latch_q  <= latch_n;
            cnt_q    <= cnt_n;
            reload_q <= reload_n;
        end
    end

    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
        (line_tick && !cmd.req_reload && !reload_q && cnt_q != '0)
            |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (line_tick && (reload_q || cnt_q == '0) && !cmd.set_latch)
            |=> (cnt_q == $past(latch_q)) && !reload_q);

    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd.req_reload && !line_tick) |=> (cnt_q == '0) && reload_q);

    a_r1_latch: assert property (@(posedge clk) disable iff (rst)
        cmd.set_latch |=> latch_q == $past(cmd.data));

    a_r8_reset: assert property (@(posedge clk)
        rst |=> (cnt_q == '0) && (latch_q == '0) && !reload_q);
endmodule

// File: rtl/scanline_irq_flag.sv
module scanline_irq_flag
    import scanline_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_cmd_t cmd,
    input  logic     hit,
    input  logic     irq_ack,
    output logic     irq_out
);
    logic en_q, pend_q, en_n, pend_n;

    always_comb begin
        en_n   = en_q;
        pend_n = pend_q;
        if (cmd.irq_off) begin
            en_n   = 1'b0;
            pend_n = 1'b0;
        end
        if (cmd.irq_on) en_n = 1'b1;
        if (irq_ack) pend_n = 1'b0;
        if (hit && en_n) pend_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
        end
    end

    assign irq_out = pend_q;

    a_r3_disable: assert property (@(posedge clk) disable iff (rst)
        cmd.irq_off |=> !en_q && !pend_q);

    a_r4_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd.irq_on && !irq_ack) |=> en_q && (pend_q || !$past(pend_q)));

    a_r9_ack_wins_unless_hit: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !hit) |=> !pend_q);

    a_r9_hit_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && (en_q || cmd.irq_on) && !cmd.irq_off) |=> pend_q);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !irq_ack && !cmd.irq_off) |=> pend_q);

    a_r6_no_raise_disabled: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !en_q && !cmd.irq_on) |=> !pend_q);
endmodule

// File: rtl/scanline_irq_top.sv
module scanline_irq_top
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_tick,
    input  logic              irq_ack,
    output logic              irq_out
);
    irq_cmd_t cmd;
    logic     hit;

    scanline_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    scanline_irq_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .line_tick (line_tick),
        .hit       (hit)
    );

    scanline_irq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .hit     (hit),
        .irq_ack (irq_ack),
        .irq_out (irq_out)
    );
endmodule

// File: tb/scanline_irq_top_tb.sv
module scanline_irq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_out;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    scanline_irq_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_tick(line_tick), .irq_ack(irq_ack),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic       wr;
        logic [15:0] addr;
        logic [7:0] data;
        logic       tick;
        logic       ack;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 39;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,16'hC000,8'h03,1'b0,1'b0,1'b0,4'd1},  // R1 latch=3
        {1'b1,16'hC001,8'h00,1'b0,1'b0,1'b0,4'd2},  // R2 reload request
        {1'b1,16'hE001,8'h00,1'b0,1'b0,1'b0,4'd4},  // R4 enable
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // R5 load 3
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 2
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 1
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b1,4'd6},  // R6 0 -> request
        {1'b0,16'h0000,8'h00,1'b0,1'b0,1'b1,4'd6},  // level held
        {1'b1,16'hE000,8'h00,1'b0,1'b0,1'b0,4'd3},  // R3 disable clears
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // reload 3
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 2
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 1
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd6},  // 0, disabled: none
        {1'b1,16'hE001,8'h00,1'b0,1'b0,1'b0,4'd4},  // enable, no tick
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // reload 3
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 2
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 1
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b1,4'd6},  // request
        {1'b1,16'hE001,8'h00,1'b0,1'b0,1'b1,4'd4},  // R4 enable keeps request
        {1'b0,16'h0000,8'h00,1'b0,1'b1,1'b0,4'd9},  // R9 ack clears
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // reload 3
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 2
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd5},  // 1
        {1'b0,16'h0000,8'h00,1'b1,1'b1,1'b1,4'd9},  // R9 tick beats ack
        {1'b0,16'h0000,8'h00,1'b0,1'b1,1'b0,4'd9},  // ack
        {1'b1,16'h6000,8'h00,1'b0,1'b0,1'b0,4'd11}, // R11 outside window
        {1'b1,16'hA001,8'h00,1'b0,1'b0,1'b0,4'd11}, // R11 outside window
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd11}, // latch still 3
        {1'b1,16'hC001,8'h00,1'b1,1'b0,1'b0,4'd10}, // R10 reload+tick -> 3
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd10}, // 2
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd10}, // 1
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b1,4'd10}, // 0 -> request
        {1'b0,16'h0000,8'h00,1'b0,1'b1,1'b0,4'd9},  // ack
        {1'b1,16'hC000,8'h00,1'b1,1'b0,1'b1,4'd7},  // R7 latch 0 with tick
        {1'b0,16'h0000,8'h00,1'b0,1'b1,1'b0,4'd9},  // ack
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b1,4'd7},  // R7 every tick
        {1'b0,16'h0000,8'h00,1'b1,1'b1,1'b1,4'd7},  // R7 again, beats ack
        {1'b1,16'hE000,8'h00,1'b1,1'b0,1'b0,4'd10}, // R10 disable before tick
        {1'b0,16'h0000,8'h00,1'b1,1'b0,1'b0,4'd6}   // disabled
    };

    task automatic check(input logic exp, input int req, input string what);
        n_cmp++;
        if (irq_out !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: irq_out=%b expected=%b", req, what, irq_out, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [15:0] a, input logic [7:0] d,
                         input logic t, input logic k);
        wr_en = w; wr_addr = a; wr_data = d; line_tick = t; irq_ack = k;
        @(negedge clk);
        wr_en = 1'b0; line_tick = 1'b0; irq_ack = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run hung, irq_out=%b expected=finish", irq_out);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        check(1'b0, 8, "R8 reset state");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            v = vec_t'(VEC[i]);
            drive(v.wr, v.addr, v.data, v.tick, v.ack);
            check(v.exp, int'(v.req), $sformatf("vector %0d", i));
        end
        // R8: reset while a request is up, then latch must be 0 again
        drive(1'b1, 16'hE001, 8'h00, 1'b0, 1'b0);
        drive(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0);
        check(1'b1, 6, "request before reset");
        rst = 1'b1;
        @(negedge clk);
        check(1'b0, 8, "R8 reset clears request");
        rst = 1'b0;
        drive(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0);
        check(1'b0, 8, "R8 enable cleared by reset");
        drive(1'b1, 16'hE001, 8'h00, 1'b0, 1'b0);
        drive(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0);
        check(1'b1, 8, "R8 latch reset to 0");
        // R3: disable without tick drops request
        drive(1'b1, 16'hFFFE, 8'h00, 1'b0, 1'b0);
        check(1'b0, 3, "disable at top of window");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule